// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a slow down-counting watchdog for a system-on-chip. Software controls it with one write strobe that carries three fields: a start value, a command bit (start or stop) and a 7-bit key. A start command loads the counter and sets it running. From then on the counter decrements once per prescaler period, which is 2^PRE_W main-clock cycles. With a 100 MHz core clock and PRE_W = 17, that is about 763 Hz.

When the count stands at 1, the block raises a non-maskable interrupt request. This gives the handler one full period to react. If the count then reaches its end, the block issues a one-cycle chip reset request.

To stop a runaway program from keeping the dog alive by repeating one write, every command must carry the bitwise inverse of the key in the previously accepted command. Any other write is dropped. After reset the dog is stopped, and the first command may carry any key. Software feeds the dog by issuing a start command again, which reloads the count.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, nmi_req and rst_req are low, the counter is stopped, and the first write is accepted whatever its key.
- R2: A write is accepted only when wr_key equals the stored key XOR 7'h7F. An accepted write stores its own wr_key as the new stored key.
- R3: A write whose key does not match is ignored. It changes neither the count, the running state nor the stored key.
- R4: An accepted start (wr_cmd = 1) loads wr_count and clears the prescaler. The count then decrements at write edge + k*2^PRE_W cycles for k = 1, 2, and so on.
- R5: An accepted stop (wr_cmd = 0) halts counting. It drops nmi_req from the cycle after the write, and no later rst_req follows.
- R6: nmi_req is high in every cycle the dog is running with a count of 1. This includes the cycle right after a start with wr_count = 1. It stays high until a reload, a stop or expiry.
- R7: When a decrement is due while the count is 1, rst_req is high for exactly one cycle. At the same time nmi_req falls and the dog stops.
- R8: A start accepted while running reloads the count from wr_count. Feeding therefore postpones both requests.
- R9: A start with wr_count = 0 gives rst_req at the first decrement point, with no nmi_req before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, one cycle per command |
| wr_cmd | input | 1 | Command: 1 = start/feed, 0 = stop |
| wr_count | input | CNT_W | Start value loaded by a start command |
| wr_key | input | KEY_W | Key carried by the command |
| nmi_req | output | 1 | Non-maskable interrupt request, registered |
| rst_req | output | 1 | Chip reset request pulse, registered |

## Verification
Let edge E be the clock edge that samples an accepted start. Key acceptance shows one cycle later: a stop clears nmi_req, and a start with count 1 raises it. The n-th decrement lands on edge E + n*2^PRE_W. For a start value N ≥ 2, nmi_req is therefore due after edge E + (N-1)*2^PRE_W, and rst_req after edge E + N*2^PRE_W, for one cycle only. The bench uses a short prescaler and drives inputs on falling edges. After each write it counts whole cycles from E and samples on the falling edge just after the edge where a result is due. A cycle-level model written from the requirements is compared with both outputs on every falling edge, so a late, early or stretched request is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic {
    CMD_STOP  = 1'b0,
    CMD_START = 1'b1
  } wd_cmd_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic             tick,
  output logic [PRE_W-1:0] pre_q
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  assign tick = en && (pre_q == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) pre_q <= '0;
    else if (en)    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_keycheck.sv
module wdog_keycheck #(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  output logic             accept,
  output logic [KEY_W-1:0] key_q,
  output logic             key_vld
);
  logic [KEY_W-1:0] want_key;

  assign want_key = ~key_q;
  assign accept   = wr_en && (!key_vld || (wr_key == want_key));

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q   <= '0;
      key_vld <= 1'b0;
    end else if (accept) begin
      key_q   <= wr_key;
      key_vld <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             cmd,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             run_q,
  output logic             nmi_req,
  output logic             rst_req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, n_cnt;
  logic             n_run, expire;

  always_comb begin
    n_run  = run_q;
    n_cnt  = cnt_q;
    expire = 1'b0;
    if (accept) begin
      if (wd_cmd_e'(cmd) == CMD_START) begin
        n_run = 1'b1;
        n_cnt = load_val;
      end else begin
        n_run = 1'b0;
      end
    end else if (tick) begin
      if (cnt_q <= ONE) begin
        n_cnt  = '0;
        n_run  = 1'b0;
        expire = 1'b1;
      end else begin
        n_cnt = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      nmi_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      run_q   <= n_run;
      cnt_q   <= n_cnt;
      nmi_req <= n_run && (n_cnt == ONE);
      rst_req <= expire;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CNT_W = 8,
  parameter int KEY_W = 7,
  parameter int PRE_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_cmd,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             rst_req
);
  logic             accept, key_vld, run_q, tick, pre_clr;
  logic [KEY_W-1:0] key_q;
  logic [PRE_W-1:0] pre_q;

  assign pre_clr = accept && wr_cmd;

  wdog_keycheck #(.KEY_W(KEY_W)) u_key (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_key(wr_key),
    .accept(accept), .key_q(key_q), .key_vld(key_vld)
  );

  wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .en(run_q),
    .tick(tick), .pre_q(pre_q)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .accept(accept), .cmd(wr_cmd),
    .load_val(wr_count), .tick(tick), .run_q(run_q),
    .nmi_req(nmi_req), .rst_req(rst_req)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int KEY_W = 7,
  parameter int PRE_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             wr_cmd,
  input logic [KEY_W-1:0] wr_key,
  input logic             nmi_req,
  input logic             rst_req,
  input logic             accept,
  input logic [KEY_W-1:0] key_q,
  input logic             key_vld,
  input logic             run_q,
  input logic [PRE_W-1:0] pre_q
);
  logic [KEY_W-1:0] inv_key;
  assign inv_key = key_q ^ {KEY_W{1'b1}};

  p_first_key_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !key_vld) |-> accept);

  p_key_store_r2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (key_vld && key_q == $past(wr_key)));

  p_key_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && key_vld && wr_key != inv_key) |=> $stable(key_q));

  p_pre_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && wr_cmd) |=> (pre_q == '0 && run_q));

  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && !wr_cmd) |=> (!run_q && !nmi_req));

  p_nmi_running_r6: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> run_q);

  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  p_rst_stops_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (!run_q && !nmi_req));
endmodule

bind keyed_watchdog wdog_checker #(.KEY_W(KEY_W), .PRE_W(PRE_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_key(wr_key),
  .nmi_req(nmi_req), .rst_req(rst_req), .accept(accept), .key_q(key_q),
  .key_vld(key_vld), .run_q(run_q), .pre_q(pre_q)
);

// File: tb/keyed_watchdog_tb_top.sv
`timescale 1ns/1ps
module keyed_watchdog_tb_top;
  localparam int CW = 8;
  localparam int KW = 7;
  localparam int PW = 4;
  localparam int PERIOD = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_cmd = 1'b0;
  logic [CW-1:0] wr_count = '0;
  logic [KW-1:0] wr_key = '0;
  logic nmi_req, rst_req;

  int vec = 0, miss = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog #(.CNT_W(CW), .KEY_W(KW), .PRE_W(PW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_count(wr_count), .wr_key(wr_key), .nmi_req(nmi_req), .rst_req(rst_req)
  );

  // reference model, written from the requirements
  logic          m_run, m_kv, m_nmi, m_rst;
  logic [CW-1:0] m_cnt;
  logic [PW-1:0] m_pre;
  logic [KW-1:0] m_key;

  always @(posedge clk) begin
    logic acc, tk, nr, ex;
    logic [CW-1:0] nc;
    if (rst) begin
      m_run <= 0; m_kv <= 0; m_nmi <= 0; m_rst <= 0;
      m_cnt <= 0; m_pre <= 0; m_key <= 0;
    end else begin
      acc = wr_en && (!m_kv || wr_key == (m_key ^ 7'h7F));
      tk  = m_run && (m_pre == {PW{1'b1}});
      nr = m_run; nc = m_cnt; ex = 0;
      if (acc) begin
        m_key <= wr_key; m_kv <= 1;
        if (wr_cmd) begin nr = 1; nc = wr_count; end else nr = 0;
      end else if (tk) begin
        if (m_cnt <= 1) begin nc = 0; nr = 0; ex = 1; end
        else nc = m_cnt - 1;
      end
      if (acc && wr_cmd) m_pre <= 0;
      else if (m_run)    m_pre <= m_pre + 1'b1;
      m_run <= nr; m_cnt <= nc;
      m_nmi <= nr && (nc == 1);
      m_rst <= ex;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R6 model nmi_req", nmi_req, m_nmi);
      chk("R7 model rst_req", rst_req, m_rst);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic cmd, input logic [CW-1:0] cnt, input logic [KW-1:0] key);
    wr_en = 1'b1; wr_cmd = cmd; wr_count = cnt; wr_key = key;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [KW-1:0] next_key(input logic [KW-1:0] k);
    return k ^ 7'h7F;
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miss++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    wait_n(3);
    rst = 1'b0;
    cmp_on = 1'b1;
    wait_n(1);
    // R1: reset state
    chk("R1 reset nmi_req", nmi_req, 1'b0);
    chk("R1 reset rst_req", rst_req, 1'b0);
    wait_n(40);
    chk("R1 stopped after reset", rst_req | nmi_req, 1'b0);

    // R1/R4/R6/R7: first command with arbitrary key, start value 3
    wr(1'b1, 8'd3, 7'h2A);
    wait_n(2*PERIOD - 1);
    chk("R4 nmi not yet", nmi_req, 1'b0);
    wait_n(1);
    chk("R6 nmi at count 1", nmi_req, 1'b1);
    wait_n(PERIOD - 1);
    chk("R6 nmi held", nmi_req, 1'b1);
    chk("R7 no early reset", rst_req, 1'b0);
    wait_n(1);
    chk("R7 reset pulse", rst_req, 1'b1);
    chk("R7 nmi falls at expiry", nmi_req, 1'b0);
    wait_n(1);
    chk("R7 pulse one cycle", rst_req, 1'b0);

    // R3: repeating the same key is ignored
    wr(1'b1, 8'd1, 7'h2A);
    chk("R3 wrong key no load", nmi_req, 1'b0);
    wait_n(3*PERIOD);
    chk("R3 still stopped", nmi_req | rst_req, 1'b0);

    // R2/R3: inverted key accepted, repeat of it ignored mid-run
    wr(1'b1, 8'd2, 7'h55);
    wait_n(7);
    wr(1'b1, 8'd9, 7'h55);
    wait_n(PERIOD - 8);
    chk("R2 R3 nmi on original schedule", nmi_req, 1'b1);

    // R8/R4: feed reloads, prescaler restarts from zero
    wr(1'b1, 8'd4, 7'h2A);
    chk("R8 feed drops nmi", nmi_req, 1'b0);
    wait_n(3*PERIOD - 1);
    chk("R4 prescaler cleared, no nmi yet", nmi_req, 1'b0);
    wait_n(1);
    chk("R4 nmi after three periods", nmi_req, 1'b1);

    // R5: stop with correct key
    wr(1'b0, 8'd0, 7'h55);
    chk("R5 stop drops nmi", nmi_req, 1'b0);
    wait_n(5*PERIOD);
    chk("R5 no reset after stop", nmi_req | rst_req, 1'b0);

    // R9: start value zero
    wr(1'b1, 8'd0, 7'h2A);
    chk("R9 no nmi for zero", nmi_req, 1'b0);
    wait_n(PERIOD - 1);
    chk("R9 no early reset", rst_req, 1'b0);
    wait_n(1);
    chk("R9 reset at first tick", rst_req, 1'b1);

    // R6: start value one raises nmi at once
    wait_n(2);
    wr(1'b1, 8'd1, 7'h55);
    chk("R6 nmi right after load of 1", nmi_req, 1'b1);
    wait_n(PERIOD);
    chk("R7 reset after count 1", rst_req, 1'b1);
    wait_n(2);

    // random phase, checked by the model every cycle (R2 R3 R4 R5 R6 R7 R8)
    for (int i = 0; i < 500; i++) begin
      logic [KW-1:0] k;
      wait_n($urandom_range(0, 3*PERIOD));
      if ($urandom_range(0, 9) < 7) k = next_key(m_key);
      else k = KW'($urandom);
      wr(1'b1 ^ ($urandom_range(0, 5) == 0), CW'($urandom_range(0, 5)), k);
    end
    wait_n(8*PERIOD);
    finish_run();
  end
endmodule